// File: doc/BRIEF.md
# Half-Bridge Gate Timing Generator

This block produces the two gate-drive signals of a half-bridge, low side and high side, from a simple digital oscillator. Every oscillator period has two parts. First comes a conduction interval, in which exactly one of the two outputs is high. Then comes a dead band, in which both outputs are low. A toggle bit flips once per period and chooses which output the next conduction interval goes to. Because of this, the two sides always receive the same number of conduction intervals, and each interval has the same length.

The conduction length and the dead-band length are separate inputs, both counted in clock cycles. Both values are captured at the start of each period, so a change made in the middle of a period never shortens a pulse that is already running. When the enable is removed, both gates go low on the next clock. When the enable returns, the first conduction interval always goes to the low side, so that a bootstrap capacitor is charged before the high side is driven. The block also gives two one-clock strobes. The first marks the end of each low-side pulse, for a cycle-synchronous current check. The second marks the start of every period.

Top module: `hbgt_top`

## Requirements
- R1: While the synchronous reset is high, and on the first clock after it is released with enable low, `gate_lo`, `gate_hi`, `lo_off_stb` and `period_stb` are all 0.
- R2: Each conduction interval lasts exactly `cond_len` clocks, with exactly one gate high. A `cond_len` of 0 is handled as 1.
- R3: Conduction intervals alternate between `gate_lo` and `gate_hi`. The first interval after enable rises goes to `gate_lo`.
- R4: Every conduction interval is followed by a dead band of exactly `dead_len` clocks, with both gates low. A `dead_len` of 0 is handled as 1.
- R5: `gate_lo` and `gate_hi` are never high in the same cycle.
- R6: `cond_len` and `dead_len` are sampled only in the first clock of each period. A change made later takes effect in the following period and does not alter the current conduction interval or dead band.
- R7: If `enable` is low at a clock edge, both gates are low from that edge on. On re-enable the sequence starts again with `gate_lo`.
- R8: `lo_off_stb` is high for exactly one clock. That clock is the first dead-band cycle after a `gate_lo` interval completes its full length. A shutdown caused by `enable` does not raise it.
- R9: `period_stb` is high for exactly one clock, in the first clock of every conduction interval.
- R10: Over any whole number of period pairs with fixed lengths, `gate_lo` and `gate_hi` are high for the same number of clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the oscillator. Low forces both gates low |
| cond_len | input | CNT_W | Conduction interval length in clocks (0 is handled as 1) |
| dead_len | input | CNT_W | Dead-band length in clocks (0 is handled as 1) |
| gate_lo | output | 1 | Low-side gate drive |
| gate_hi | output | 1 | High-side gate drive |
| lo_off_stb | output | 1 | One-clock pulse when a low-side pulse ends normally |
| period_stb | output | 1 | One-clock pulse at the start of each conduction interval |

## Verification
Two events can land in the same cycle: a shutdown through `enable` and the natural end of a conduction interval. In that cycle the shutdown must win. It must clear both gates and must not raise `lo_off_stb`. The bench provokes this by dropping `enable` during a high-side interval and during the last clock of a low-side interval. It then checks that both gates are low at the very next sample, that no strobe appears, and that restarting hands the first pulse to the low side. A length change written during a running conduction interval is also checked: the bench confirms that the old lengths finish the current period and the new lengths begin with the next one.

// File: rtl/hbgt_pkg.sv
package hbgt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_DEAD   = 2'd2
    } phase_e;

    localparam logic SIDE_LO = 1'b0;
    localparam logic SIDE_HI = 1'b1;

endpackage

// File: rtl/hbgt_floor1.sv
// Maps a programmed length of zero to a length of one clock.
module hbgt_floor1 #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] eff_o
);
    always_comb begin
        eff_o = raw_i;
        if (raw_i == '0) begin
            eff_o = W'(1);
        end
    end
endmodule

// File: rtl/hbgt_seq.sv
// Phase sequencer: conduction interval, then dead band, with a side toggle.
module hbgt_seq
    import hbgt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cond_i,
    input  logic [CNT_W-1:0] dead_i,
    output phase_e           phase_o,
    output logic             side_o,
    output logic             start_o,
    output logic             lo_end_o
);
    typedef struct packed {
        phase_e           ph;
        logic             side;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] dl;
    } seq_t;

    seq_t seq_d, seq_q;
    logic start_d, lo_end_d;

    always_comb begin
        seq_d    = seq_q;
        start_d  = 1'b0;
        lo_end_d = 1'b0;
        if (!en_i) begin
            seq_d.ph   = PH_IDLE;
            seq_d.side = SIDE_LO;
            seq_d.cnt  = '0;
        end else begin
            unique case (seq_q.ph)
                PH_IDLE: begin
                    seq_d.ph   = PH_ACTIVE;
                    seq_d.side = SIDE_LO;
                    seq_d.cnt  = cond_i - CNT_W'(1);
                    seq_d.dl   = dead_i;
                    start_d    = 1'b1;
                end
                PH_ACTIVE: begin
                    if (seq_q.cnt == '0) begin
                        seq_d.ph  = PH_DEAD;
                        seq_d.cnt = seq_q.dl - CNT_W'(1);
                        lo_end_d  = (seq_q.side == SIDE_LO);
                    end else begin
                        seq_d.cnt = seq_q.cnt - CNT_W'(1);
                    end
                end
                PH_DEAD: begin
                    if (seq_q.cnt == '0) begin
                        seq_d.ph   = PH_ACTIVE;
                        seq_d.side = ~seq_q.side;
                        seq_d.cnt  = cond_i - CNT_W'(1);
                        seq_d.dl   = dead_i;
                        start_d    = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt - CNT_W'(1);
                    end
                end
                default: begin
                    seq_d.ph   = PH_IDLE;
                    seq_d.side = SIDE_LO;
                    seq_d.cnt  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.ph   <= PH_IDLE;
            seq_q.side <= SIDE_LO;
            seq_q.cnt  <= '0;
            seq_q.dl   <= CNT_W'(1);
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o  = seq_q.ph;
    assign side_o   = seq_q.side;
    assign start_o  = start_d;
    assign lo_end_o = lo_end_d;
endmodule

// File: rtl/hbgt_drive.sv
// Gate decode from registered phase and side, plus registered strobes.
module hbgt_drive
    import hbgt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase_i,
    input  logic   side_i,
    input  logic   start_i,
    input  logic   lo_end_i,
    output logic   lo_o,
    output logic   hi_o,
    output logic   lo_off_o,
    output logic   period_o
);
    typedef struct packed {
        logic lo_off;
        logic period;
    } stb_t;

    stb_t stb_d, stb_q;

    always_comb begin
        stb_d.lo_off = lo_end_i;
        stb_d.period = start_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= '0;
        end else begin
            stb_q <= stb_d;
        end
    end

    assign lo_o     = (phase_i == PH_ACTIVE) && (side_i == SIDE_LO);
    assign hi_o     = (phase_i == PH_ACTIVE) && (side_i == SIDE_HI);
    assign lo_off_o = stb_q.lo_off;
    assign period_o = stb_q.period;
endmodule

// File: rtl/hbgt_top.sv
module hbgt_top
    import hbgt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] cond_len,
    input  logic [CNT_W-1:0] dead_len,
    output logic             gate_lo,
    output logic             gate_hi,
    output logic             lo_off_stb,
    output logic             period_stb
);
    localparam int N_LEN = 2;

    logic [CNT_W-1:0] len_raw [N_LEN];
    logic [CNT_W-1:0] len_eff [N_LEN];

    assign len_raw[0] = cond_len;
    assign len_raw[1] = dead_len;

    for (genvar g = 0; g < N_LEN; g++) begin : g_floor
        hbgt_floor1 #(.W(CNT_W)) u_floor (
            .raw_i (len_raw[g]),
            .eff_o (len_eff[g])
        );
    end

    phase_e phase;
    logic   side, start, lo_end;

    hbgt_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .en_i     (enable),
        .cond_i   (len_eff[0]),
        .dead_i   (len_eff[1]),
        .phase_o  (phase),
        .side_o   (side),
        .start_o  (start),
        .lo_end_o (lo_end)
    );

    hbgt_drive u_drive (
        .clk      (clk),
        .rst      (rst),
        .phase_i  (phase),
        .side_i   (side),
        .start_i  (start),
        .lo_end_i (lo_end),
        .lo_o     (gate_lo),
        .hi_o     (gate_hi),
        .lo_off_o (lo_off_stb),
        .period_o (period_stb)
    );
endmodule

// File: rtl/hbgt_checker.sv
module hbgt_checker (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic gate_lo,
    input logic gate_hi,
    input logic lo_off_stb,
    input logic period_stb
);
    // R5
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
        !(gate_lo && gate_hi));

    // R7
    p_disable_low_r7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!gate_lo && !gate_hi));

    // R3
    p_start_lo_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(enable) |=> (gate_lo && !gate_hi));

    // R8
    p_lo_off_edge_r8: assert property (@(posedge clk) disable iff (rst)
        lo_off_stb |-> (!gate_lo && !gate_hi && $past(gate_lo)));

    // R8
    p_lo_off_single_r8: assert property (@(posedge clk) disable iff (rst)
        lo_off_stb |=> !lo_off_stb);

    // R9
    p_period_gate_r9: assert property (@(posedge clk) disable iff (rst)
        period_stb |-> (gate_lo || gate_hi));

    // R4
    p_dead_between_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate_lo) || $fell(gate_hi)) |-> (!gate_lo && !gate_hi));
endmodule

bind hbgt_top hbgt_checker u_checker (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .gate_lo    (gate_lo),
    .gate_hi    (gate_hi),
    .lo_off_stb (lo_off_stb),
    .period_stb (period_stb)
);

// File: tb/hbgt_top_tb.sv
module hbgt_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             enable;
    logic [CNT_W-1:0] cond_len;
    logic [CNT_W-1:0] dead_len;
    logic             gate_lo, gate_hi, lo_off_stb, period_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int lo_clks  = 0;
    int hi_clks  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbgt_top #(.CNT_W(CNT_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .cond_len   (cond_len),
        .dead_len   (dead_len),
        .gate_lo    (gate_lo),
        .gate_hi    (gate_hi),
        .lo_off_stb (lo_off_stb),
        .period_stb (period_stb)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // R5: overlap watched on every sample, plus high-clock counts for R10
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R5", "gates overlap", gate_lo && gate_hi, 1'b0);
            if (gate_lo) lo_clks++;
            if (gate_hi) hi_clks++;
        end
    end

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Checks n whole periods. The sampler must sit on the first conduction sample.
    task automatic expect_periods(input int a, input int d, input int n, input logic side0);
        for (int p = 0; p < n; p++) begin
            logic side;
            side = side0 ^ logic'(p[0]);
            for (int i = 0; i < eff(a); i++) begin
                chk("R2", "lo in conduction", gate_lo, !side);
                chk("R3", "hi in conduction", gate_hi, side);
                chk("R9", "period strobe", period_stb, i == 0);
                chk("R8", "lo_off in conduction", lo_off_stb, 1'b0);
                @(negedge clk);
            end
            for (int i = 0; i < eff(d); i++) begin
                chk("R4", "lo in dead band", gate_lo, 1'b0);
                chk("R4", "hi in dead band", gate_hi, 1'b0);
                chk("R8", "lo_off in dead band", lo_off_stb, (i == 0) && !side);
                chk("R9", "period strobe in dead band", period_stb, 1'b0);
                @(negedge clk);
            end
        end
    endtask

    task automatic go_idle();
        enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic start(input int a, input int d);
        cond_len = CNT_W'(a);
        dead_len = CNT_W'(d);
        enable   = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R1", "lo in reset", gate_lo, 1'b0);
        chk("R1", "hi in reset", gate_hi, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "lo after reset", gate_lo, 1'b0);
        chk("R1", "hi after reset", gate_hi, 1'b0);
        chk("R1", "lo_off after reset", lo_off_stb, 1'b0);
        chk("R1", "period after reset", period_stb, 1'b0);
    endtask

    task automatic test_basic();
        start(3, 2);
        expect_periods(3, 2, 4, 1'b0);
        go_idle();
        start(1, 5);
        expect_periods(1, 5, 3, 1'b0);
        go_idle();
    endtask

    task automatic test_zero();
        // R2 and R4: zero lengths are handled as one clock
        start(0, 0);
        expect_periods(0, 0, 4, 1'b0);
        go_idle();
    endtask

    task automatic test_change();
        start(3, 2);
        chk("R6", "lo first clock", gate_lo, 1'b1);
        chk("R9", "period first clock", period_stb, 1'b1);
        cond_len = CNT_W'(5);
        dead_len = CNT_W'(4);
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk("R6", "old conduction kept", gate_lo, 1'b1);
            @(negedge clk);
        end
        for (int i = 0; i < 2; i++) begin
            chk("R6", "old dead band kept lo", gate_lo, 1'b0);
            chk("R6", "old dead band kept hi", gate_hi, 1'b0);
            @(negedge clk);
        end
        expect_periods(5, 4, 2, 1'b1);
        go_idle();
    endtask

    task automatic test_disable();
        start(2, 1);
        expect_periods(2, 1, 1, 1'b0);
        chk("R7", "hi running", gate_hi, 1'b1);
        enable = 1'b0;
        @(negedge clk);
        chk("R7", "lo after disable", gate_lo, 1'b0);
        chk("R7", "hi after disable", gate_hi, 1'b0);
        chk("R8", "no lo_off on disable", lo_off_stb, 1'b0);
        repeat (2) @(negedge clk);
        chk("R7", "hi held low", gate_hi, 1'b0);
        start(2, 1);
        chk("R7", "restart on lo", gate_lo, 1'b1);
        chk("R3", "restart not hi", gate_hi, 1'b0);
        // shutdown on the last clock of a low-side pulse
        @(negedge clk);
        chk("R7", "lo last clock", gate_lo, 1'b1);
        enable = 1'b0;
        @(negedge clk);
        chk("R8", "no lo_off when shut at end", lo_off_stb, 1'b0);
        chk("R7", "lo off at end shutdown", gate_lo, 1'b0);
        go_idle();
    endtask

    task automatic test_split();
        start(4, 3);
        lo_clks = 0;
        hi_clks = 0;
        expect_periods(4, 3, 6, 1'b0);
        chk("R10", "split equal", lo_clks == hi_clks, 1'b1);
        chk("R10", "lo clock count", lo_clks == 12, 1'b1);
        go_idle();
    endtask

    initial begin
        rst      = 1'b1;
        enable   = 1'b0;
        cond_len = '0;
        dead_len = '0;
        repeat (2) @(negedge clk);
        test_reset();
        test_basic();
        test_zero();
        test_change();
        test_disable();
        test_split();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule